// File: doc/BRIEF.md
# Shadow-Stack Page Content Checker

This block inspects a page of memory, just copied into protected storage, that is meant to become a shadow-stack page inside an isolated address range. A start strobe captures the page's context: whether the page is the first page of a shadow stack or a continuation page, its linear address, the base and size of the range it belongs to, a 64-bit-mode bit, and the read, write and execute flags requested for it. The page then streams in as 64-bit words, with a valid qualifier and a last marker.

The checker needs the whole page to be zero except its final word. That final word must be zero for a continuation page. For a first page it must hold a restore token, which is the page's own address plus one page, OR'd with the mode bit. The checker also rejects a page placed at the lowest or highest page slot of the range, and any flag combination other than read and write without execute. One cycle after the final word is taken, a done strobe pulses and a pass/fail result appears. The result holds until the next start.

Top module: `ss_page_checker`

## Requirements
- R1: After reset `done_o` and `pass_o` are 0, and the block is idle. Words presented while idle, including ones marked last, produce no `done_o` pulse.
- R2: `start_i` captures all configuration inputs. Configuration inputs that change after the start cycle have no effect on the result.
- R3: Every word at index 0 to 510 of the page (bytes 0 to 4087) must be zero. Any nonzero bit in any of them makes the result fail.
- R4: When `kind_i`=1 (first page), word 511 must equal `(lin_addr_i + 4096) | mode64_i`, with the mode bit OR'd into bit 0. Otherwise the result fails.
- R5: When `kind_i`=0 (continuation page), word 511 must be zero. Otherwise the result fails.
- R6: The result fails when `lin_addr_i` equals `base_i`, or when it equals `base_i + size_i - 4096`.
- R7: The result fails unless `perm_r_i`=1, `perm_w_i`=1 and `perm_x_i`=0.
- R8: The result fails when `word_last_i` is accepted on a word count other than 512, whether the page is shorter or longer.
- R9: `done_o` is high for exactly one cycle, in the cycle after the accepted last word. `pass_o` is valid from that cycle and holds until the next start.
- R10: `start_i` clears `pass_o` in the next cycle. A start during a stream discards the stream in progress and begins a fresh page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a page check and capture the configuration |
| kind_i | input | 1 | 1 = first shadow-stack page, 0 = continuation page |
| lin_addr_i | input | 64 | Linear address of the page |
| base_i | input | 64 | Base address of the enclosing range |
| size_i | input | 64 | Size of the enclosing range in bytes |
| mode64_i | input | 1 | 64-bit-mode bit folded into the token |
| perm_r_i | input | 1 | Requested read permission |
| perm_w_i | input | 1 | Requested write permission |
| perm_x_i | input | 1 | Requested execute permission |
| word_valid_i | input | 1 | Page word is presented this cycle |
| word_data_i | input | 64 | Page word |
| word_last_i | input | 1 | Presented word is the final one |
| done_o | output | 1 | One-cycle strobe, result ready |
| pass_o | output | 1 | Page accepted (valid with and after `done_o`) |

## Verification
Directed pages cover several cases. Clean first pages use both mode-bit values and clean continuation pages use 0. Single-word corruptions at index 0, index 510 and the token word show whether the zero check covers the last zero word but leaves the token word to its own comparison. Placements at the lowest page, the highest page and an interior page show the two forbidden slots apart from legal ones. Each illegal flag combination, 511- and 513-word streams, and a start issued mid-stream cover the flag, length and restart rules. Random pages with random valid gaps then mix all faults. Each result is compared with a bench model computed over the same page image.

// File: rtl/ss_page_checker.sv
module ss_page_checker #(
  parameter int DATA_W     = 64,
  parameter int PAGE_WORDS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              kind_i,
  input  logic [DATA_W-1:0] lin_addr_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] size_i,
  input  logic              mode64_i,
  input  logic              perm_r_i,
  input  logic              perm_w_i,
  input  logic              perm_x_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_data_i,
  input  logic              word_last_i,
  output logic              done_o,
  output logic              pass_o
);
  localparam int CNT_W = $clog2(PAGE_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAGE_WORDS - 1);
  localparam logic [CNT_W-1:0] MAX_IDX  = CNT_W'(PAGE_WORDS);
  localparam logic [DATA_W-1:0] PAGE_SPAN = DATA_W'(PAGE_WORDS * (DATA_W / 8));

  logic              busy_q;
  logic              fail_q;
  logic [CNT_W-1:0]  idx_q;
  logic [DATA_W-1:0] token_q;

  logic              cfg_bad;
  logic [DATA_W-1:0] token_d;
  logic              take;
  logic              word_bad;
  logic              len_bad;

  assign cfg_bad = (lin_addr_i == base_i) ||
                   (lin_addr_i == base_i + size_i - PAGE_SPAN) ||
                   !(perm_r_i && perm_w_i && !perm_x_i);
  assign token_d = kind_i ? ((lin_addr_i + PAGE_SPAN) | DATA_W'(mode64_i)) : '0;

  assign take     = busy_q && word_valid_i && !start_i;
  assign word_bad = (idx_q < LAST_IDX)  ? (word_data_i != '0) :
                    (idx_q == LAST_IDX) ? (word_data_i != token_q) : 1'b1;
  assign len_bad  = (idx_q != LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fail_q  <= 1'b0;
      idx_q   <= '0;
      token_q <= '0;
      done_o  <= 1'b0;
      pass_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        fail_q  <= cfg_bad;
        idx_q   <= '0;
        token_q <= token_d;
        pass_o  <= 1'b0;
      end else if (take) begin
        if (word_bad) fail_q <= 1'b1;
        if (idx_q != MAX_IDX) idx_q <= idx_q + 1'b1;
        if (word_last_i) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          pass_o <= !fail_q && !word_bad && !len_bad;
        end
      end
    end
  end

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_q && word_valid_i && word_last_i && !start_i));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o && !pass_o);

  p_pass_needs_full_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && pass_o |-> $past(idx_q) == LAST_IDX);

  p_pass_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !(busy_q && word_valid_i && word_last_i) |=> $stable(pass_o));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !start_i |=> !done_o);

  p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= MAX_IDX);
endmodule

// File: tb/test_ss_page_checker.sv
module test_ss_page_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, kind_i = 1'b0, mode64_i = 1'b0;
  logic [63:0] lin_addr_i = '0, base_i = '0, size_i = '0, word_data_i = '0;
  logic        perm_r_i = 1'b0, perm_w_i = 1'b0, perm_x_i = 1'b0;
  logic        word_valid_i = 1'b0, word_last_i = 1'b0;
  logic        done_o, pass_o;

  int checks = 0;
  int errors = 0;

  logic [63:0] pg [0:599];
  logic        c_kind, c_m64, c_r, c_w, c_x;
  logic [63:0] c_lin, c_base, c_size;
  logic        gaps = 1'b0;

  always #4 clk = ~clk;

  ss_page_checker i_ss_page_checker (.*);

  task automatic chk(input logic cond, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] tok();
    return c_kind ? ((c_lin + 64'd4096) | {63'd0, c_m64}) : 64'd0;
  endfunction

  function automatic logic exp_pass(input int n);
    logic ok;
    ok = (c_lin != c_base) && (c_lin != c_base + c_size - 64'd4096) &&
         c_r && c_w && !c_x && (n == 512);
    for (int i = 0; i < 511; i++) if (pg[i] != 0) ok = 1'b0;
    if (pg[511] != tok()) ok = 1'b0;
    return ok;
  endfunction

  task automatic set_cfg(input logic k, input logic m, input logic [63:0] b,
                         input int pages, input int slot, input logic r, w, x);
    c_kind = k; c_m64 = m; c_base = b; c_size = 64'(pages) << 12;
    c_lin = b + (64'(slot) << 12); c_r = r; c_w = w; c_x = x;
  endtask

  task automatic clean_page();
    for (int i = 0; i < 600; i++) pg[i] = '0;
    pg[511] = tok();
  endtask

  task automatic do_start();
    @(negedge clk);
    start_i = 1'b1; kind_i = c_kind; mode64_i = c_m64; lin_addr_i = c_lin;
    base_i = c_base; size_i = c_size; perm_r_i = c_r; perm_w_i = c_w; perm_x_i = c_x;
    @(negedge clk);
    start_i = 1'b0;
    // R2: scramble configuration after capture
    kind_i = ~c_kind; lin_addr_i = $urandom; base_i = $urandom; perm_x_i = ~c_x;
    chk(pass_o == 1'b0 && done_o == 1'b0, "R10 start clears result", {62'd0, done_o, pass_o}, 0);
  endtask

  task automatic stream(input int n, input logic with_last);
    for (int i = 0; i < n; i++) begin
      while (gaps && ($urandom % 4 == 0)) begin
        word_valid_i = 1'b0; word_data_i = $urandom; word_last_i = $urandom;
        @(negedge clk);
      end
      word_valid_i = 1'b1; word_data_i = pg[i]; word_last_i = with_last && (i == n - 1);
      @(negedge clk);
      if (i != n - 1 || !with_last)
        chk(done_o == 1'b0, "R9 no done mid-page", done_o, 0);
    end
    word_valid_i = 1'b0; word_last_i = 1'b0; word_data_i = '0;
  endtask

  task automatic run(input int n, input string req);
    logic e;
    e = exp_pass(n);
    do_start();
    stream(n, 1'b1);
    chk(done_o == 1'b1, "R9 done after last word", done_o, 1);
    chk(pass_o == e, req, pass_o, e);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done single cycle", done_o, 0);
    chk(pass_o == e, "R9 result holds", pass_o, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(done_o == 0 && pass_o == 0, "R1 reset state", {62'd0, done_o, pass_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    set_cfg(1, 0, 64'h0001_0000, 8, 3, 1, 1, 0);
    clean_page();
    stream(20, 1'b1);
    chk(done_o == 0, "R1 idle words ignored", done_o, 0);
    @(negedge clk);
    chk(done_o == 0 && pass_o == 0, "R1 idle no result", {62'd0, done_o, pass_o}, 0);

    set_cfg(1, 0, 64'h0001_0000, 8, 3, 1, 1, 0); clean_page(); run(512, "R4 first page mode0");
    set_cfg(1, 1, 64'h7fff_0000, 8, 5, 1, 1, 0); clean_page(); run(512, "R4 first page mode1");
    set_cfg(1, 1, 64'h7fff_0000, 8, 5, 1, 1, 0); clean_page(); pg[511] ^= 64'h1; run(512, "R4 token missing mode bit");
    set_cfg(1, 0, 64'h7fff_0000, 8, 5, 1, 1, 0); clean_page(); pg[511] = c_lin; run(512, "R4 token wrong address");
    set_cfg(0, 1, 64'h2000_0000, 4, 1, 1, 1, 0); clean_page(); run(512, "R5 rest page clean");
    set_cfg(0, 0, 64'h2000_0000, 4, 1, 1, 1, 0); clean_page(); pg[511] = 64'h8000_0000_0000_0000; run(512, "R5 rest token nonzero");
    set_cfg(0, 0, 64'h2000_0000, 4, 2, 1, 1, 0); clean_page(); pg[0] = 64'h1; run(512, "R3 word0 nonzero");
    set_cfg(1, 0, 64'h2000_0000, 4, 2, 1, 1, 0); clean_page(); pg[510] = 64'h8000_0000_0000_0000; run(512, "R3 word510 nonzero");
    set_cfg(1, 0, 64'h3000_0000, 16, 0, 1, 1, 0); clean_page(); run(512, "R6 page at base");
    set_cfg(1, 0, 64'h3000_0000, 16, 15, 1, 1, 0); clean_page(); run(512, "R6 page at top");
    set_cfg(1, 0, 64'h3000_0000, 16, 14, 1, 1, 0); clean_page(); run(512, "R6 page below top legal");
    set_cfg(1, 0, 64'h3000_0000, 16, 4, 0, 1, 0); clean_page(); run(512, "R7 no read");
    set_cfg(1, 0, 64'h3000_0000, 16, 4, 1, 0, 0); clean_page(); run(512, "R7 no write");
    set_cfg(0, 0, 64'h3000_0000, 16, 4, 1, 1, 1); clean_page(); run(512, "R7 execute set");
    set_cfg(0, 0, 64'h3000_0000, 16, 4, 1, 1, 0); clean_page(); run(511, "R8 short page");
    set_cfg(0, 0, 64'h3000_0000, 16, 4, 1, 1, 0); clean_page(); run(513, "R8 long page");

    set_cfg(1, 0, 64'h4000_0000, 16, 6, 1, 1, 0); clean_page(); pg[7] = 64'h5;
    do_start();
    stream(100, 1'b0);
    pg[7] = '0;
    run(512, "R10 restart mid-stream");

    gaps = 1'b1;
    for (int t = 0; t < 30; t++) begin
      int pages, slot, n, sel;
      pages = 3 + ($urandom % 60);
      sel = $urandom % 8;
      slot = (sel == 0) ? 0 : (sel == 1) ? pages - 1 : 1 + ($urandom % (pages - 2));
      set_cfg($urandom, $urandom, {20'd0, 32'($urandom), 12'd0}, pages, slot,
              ($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 8) == 0);
      clean_page();
      if ($urandom % 4 == 0) pg[$urandom % 511] = 64'd1 << ($urandom % 64);
      if ($urandom % 5 == 0) pg[511] = pg[511] ^ (64'd1 << ($urandom % 64));
      sel = $urandom % 8;
      n = (sel == 0) ? 1 + ($urandom % 511) : (sel == 1) ? 513 + ($urandom % 80) : 512;
      run(n, "R3 R4 R5 R6 R7 R8 random page");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule